// File: doc/BRIEF.md
# Paged Per-Channel Configuration Register File

This block holds the byte-wide configuration state of a 128-channel front-end readout chip. A host reaches it through a synchronous port with an 8-bit address. A write strobe stores a byte on the rising clock edge. Readback is combinational from the address presented on the same port.

The lower half of the address space holds flat registers. Address 0 is a control byte whose two low bits choose one of four trim pages. Sixteen calibration-enable bytes and sixteen power-down bytes each pack eight channels. They are unpacked into two 128-bit per-channel vectors that drive the analog channel logic. The upper half of the address space is a window onto the selected trim page, one byte per channel. The four pages hold:

- preamp compensation capacitor trim,
- preamp feedback offset trim,
- 10x preamp gain-stage offset trim,
- 10x shaper gain-stage offset trim.

The host selects a page through address 0 and then addresses channel n at 128+n.

Top module: `chan_cfg_regfile`

## Requirements
- R1: While reset is asserted and right after it is released, every trim byte, every mask byte and the page select are zero, so `pd_vec`, `cal_vec` and every readback are zero.
- R2: Address 0 stores the page select in bits [1:0]. Reading address 0 returns the page in bits [1:0] and zero in bits [7:2]. Written values of bits [7:2] are discarded.
- R3: An access to address 128+n (n = 0..127) reaches the trim byte of channel n in the page held in address 0 at the time of the access. A byte written there reads back unchanged while the page is unchanged.
- R4: The four trim pages are independent storage. Changing the page select alters no stored trim byte. Selecting a page again returns the values last written to it.
- R5: Address 64+i (i = 0..15) holds calibration-enable bits. Bit k of that byte drives `cal_vec[8*i+k]`, and it reads back as written.
- R6: Address 80+i (i = 0..15) holds power-down bits. Bit k of that byte drives `pd_vec[8*i+k]`, where 1 means channel 8*i+k is powered down and 0 means it is active. It reads back as written.
- R7: A write becomes visible on `rd_data`, `pd_vec` and `cal_vec` right after the clock edge that accepts it. The vectors change at no other time.
- R8: Flat addresses 1-63 and 96-127 read as zero. Writes to them change no output and no stored value.
- R9: Writes to the paged window leave `pd_vec`, `cal_vec` and the page select unchanged. Writes to flat addresses leave every trim byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, byte stored on the next rising edge |
| addr | input | 8 | Register address for both read and write |
| wr_data | input | 8 | Byte to be written |
| rd_data | output | 8 | Combinational readback of the addressed byte |
| pd_vec | output | 128 | Per-channel power-down flags, 1 = powered down |
| cal_vec | output | 128 | Per-channel calibration-enable flags |

## Verification
A wrong page select shows up as trim readback from the wrong page. This is visible in the first cycle that the window is read after the faulty write to address 0, and the control byte itself reads back wrongly at once. A misplaced mask bit or a swapped group base shows up on `pd_vec` or `cal_vec` in the cycle right after the write, before any readback. Stray decode, where a write lands in a second place, shows up as a vector change or a nonzero read of an unused address on the next compare. The reference model is checked against the design on every cycle, so each such fault is seen within one clock.

// File: rtl/cfg_regfile_pkg.sv
package cfg_regfile_pkg;

    localparam int DEF_DATA_W    = 8;
    localparam int DEF_ADDR_W    = 8;
    localparam int DEF_NUM_CH    = 128;
    localparam int DEF_NUM_PAGES = 4;
    localparam int DEF_CAL_BASE  = 64;
    localparam int DEF_PD_BASE   = 80;

    // Which storage an address selects
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_CAL  = 3'd2,
        SEL_PD   = 3'd3,
        SEL_TRIM = 3'd4
    } sel_e;

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import cfg_regfile_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int CH_W      = 7,
    parameter int CAL_BASE  = DEF_CAL_BASE,
    parameter int PD_BASE   = DEF_PD_BASE,
    parameter int MASK_REGS = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [CH_W-1:0]   idx
);

    localparam logic [ADDR_W-1:0] CAL_LO = ADDR_W'(CAL_BASE);
    localparam logic [ADDR_W-1:0] CAL_HI = ADDR_W'(CAL_BASE + MASK_REGS);
    localparam logic [ADDR_W-1:0] PD_LO  = ADDR_W'(PD_BASE);
    localparam logic [ADDR_W-1:0] PD_HI  = ADDR_W'(PD_BASE + MASK_REGS);

    logic [ADDR_W-1:0] cal_off;
    logic [ADDR_W-1:0] pd_off;

    always_comb begin
        cal_off = addr - CAL_LO;
        pd_off  = addr - PD_LO;
        sel     = SEL_NONE;
        idx     = '0;
        if (addr[ADDR_W-1]) begin
            // upper half: per-channel window, channel = low bits
            sel = SEL_TRIM;
            idx = addr[CH_W-1:0];
        end else if (addr == '0) begin
            sel = SEL_CTRL;
        end else if (addr >= CAL_LO && addr < CAL_HI) begin
            sel = SEL_CAL;
            idx = CH_W'(cal_off);
        end else if (addr >= PD_LO && addr < PD_HI) begin
            sel = SEL_PD;
            idx = CH_W'(pd_off);
        end
    end

endmodule

// File: rtl/cfg_mask_bank.sv
module cfg_mask_bank #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDX_W-1:0]           idx,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_REGS*DATA_W-1:0] vec
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we) begin
            bank_d.regs[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rdata = bank_q.regs[idx];

    // byte g carries channels g*DATA_W .. g*DATA_W+DATA_W-1, bit k -> channel g*DATA_W+k
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
        assign vec[g*DATA_W +: DATA_W] = bank_q.regs[g];
    end

endmodule

// File: rtl/cfg_trim_pages.sv
module cfg_trim_pages #(
    parameter int DATA_W    = 8,
    parameter int NUM_CH    = 128,
    parameter int NUM_PAGES = 4,
    parameter int CH_W      = $clog2(NUM_CH),
    parameter int PAGE_W    = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PAGE_W-1:0] page,
    input  logic [CH_W-1:0]   ch,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [NUM_PAGES-1:0][NUM_CH-1:0][DATA_W-1:0] trim;
    } pages_t;

    pages_t pages_d, pages_q;

    always_comb begin
        pages_d = pages_q;
        if (we) begin
            pages_d.trim[page][ch] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pages_q <= '0;
        end else begin
            pages_q <= pages_d;
        end
    end

    assign rdata = pages_q.trim[page][ch];

endmodule

// File: rtl/chan_cfg_regfile.sv
module chan_cfg_regfile
    import cfg_regfile_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int NUM_CH    = DEF_NUM_CH,
    parameter int NUM_PAGES = DEF_NUM_PAGES,
    parameter int CAL_BASE  = DEF_CAL_BASE,
    parameter int PD_BASE   = DEF_PD_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] pd_vec,
    output logic [NUM_CH-1:0] cal_vec
);

    localparam int CH_W       = $clog2(NUM_CH);
    localparam int PAGE_W     = $clog2(NUM_PAGES);
    localparam int MASK_REGS  = NUM_CH / DATA_W;
    localparam int MASK_IDX_W = $clog2(MASK_REGS);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    sel_e                  sel;
    logic [CH_W-1:0]       dec_idx;
    logic [MASK_IDX_W-1:0] mask_idx;
    logic [DATA_W-1:0]     cal_rdata;
    logic [DATA_W-1:0]     pd_rdata;
    logic [DATA_W-1:0]     trim_rdata;
    logic                  cal_we;
    logic                  pd_we;
    logic                  trim_we;

    cfg_addr_decode #(
        .ADDR_W   (ADDR_W),
        .CH_W     (CH_W),
        .CAL_BASE (CAL_BASE),
        .PD_BASE  (PD_BASE),
        .MASK_REGS(MASK_REGS)
    ) u_dec (
        .addr(addr),
        .sel (sel),
        .idx (dec_idx)
    );

    assign mask_idx = dec_idx[MASK_IDX_W-1:0];
    assign cal_we   = wr_en && (sel == SEL_CAL);
    assign pd_we    = wr_en && (sel == SEL_PD);
    assign trim_we  = wr_en && (sel == SEL_TRIM);

    // Control byte: page select only
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && sel == SEL_CTRL) begin
            ctrl_d.page = wr_data[PAGE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    cfg_mask_bank #(
        .DATA_W  (DATA_W),
        .NUM_REGS(MASK_REGS),
        .IDX_W   (MASK_IDX_W)
    ) u_cal_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cal_we),
        .idx  (mask_idx),
        .wdata(wr_data),
        .rdata(cal_rdata),
        .vec  (cal_vec)
    );

    cfg_mask_bank #(
        .DATA_W  (DATA_W),
        .NUM_REGS(MASK_REGS),
        .IDX_W   (MASK_IDX_W)
    ) u_pd_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (pd_we),
        .idx  (mask_idx),
        .wdata(wr_data),
        .rdata(pd_rdata),
        .vec  (pd_vec)
    );

    cfg_trim_pages #(
        .DATA_W   (DATA_W),
        .NUM_CH   (NUM_CH),
        .NUM_PAGES(NUM_PAGES),
        .CH_W     (CH_W),
        .PAGE_W   (PAGE_W)
    ) u_trim (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (trim_we),
        .page (ctrl_q.page),
        .ch   (dec_idx),
        .wdata(wr_data),
        .rdata(trim_rdata)
    );

    // Readback mux
    always_comb begin
        unique case (sel)
            SEL_CTRL: rd_data = {{(DATA_W-PAGE_W){1'b0}}, ctrl_q.page};
            SEL_CAL:  rd_data = cal_rdata;
            SEL_PD:   rd_data = pd_rdata;
            SEL_TRIM: rd_data = trim_rdata;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/chan_cfg_regfile_chk.sv
module chan_cfg_regfile_chk
    import cfg_regfile_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [DEF_ADDR_W-1:0]    addr,
    input logic [DEF_DATA_W-1:0]    wr_data,
    input logic [DEF_DATA_W-1:0]    rd_data,
    input logic [DEF_NUM_CH-1:0]    pd_vec,
    input logic [DEF_NUM_CH-1:0]    cal_vec
);

    localparam int MASK_REGS  = DEF_NUM_CH / DEF_DATA_W;
    localparam int MASK_IDX_W = $clog2(MASK_REGS);
    localparam int PAGE_W     = $clog2(DEF_NUM_PAGES);
    localparam logic [DEF_ADDR_W-1:0] CAL_LO = DEF_ADDR_W'(DEF_CAL_BASE);
    localparam logic [DEF_ADDR_W-1:0] CAL_HI = DEF_ADDR_W'(DEF_CAL_BASE + MASK_REGS);
    localparam logic [DEF_ADDR_W-1:0] PD_LO  = DEF_ADDR_W'(DEF_PD_BASE);
    localparam logic [DEF_ADDR_W-1:0] PD_HI  = DEF_ADDR_W'(DEF_PD_BASE + MASK_REGS);

    function automatic logic [DEF_DATA_W-1:0] byte_at(input logic [DEF_NUM_CH-1:0] v,
                                                      input logic [MASK_IDX_W-1:0] i);
        return v[int'(i)*DEF_DATA_W +: DEF_DATA_W];
    endfunction

    logic in_cal, in_pd, in_win, in_unused;
    assign in_cal    = (addr >= CAL_LO) && (addr < CAL_HI);
    assign in_pd     = (addr >= PD_LO) && (addr < PD_HI);
    assign in_win    = addr[DEF_ADDR_W-1];
    assign in_unused = !in_win && (addr != '0) && !in_cal && !in_pd;

    // R1
    reset_clears_vectors_chk: assert property (@(posedge clk)
        !rst_n |=> (pd_vec == '0) && (cal_vec == '0));

    // R2
    ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0) |-> (rd_data[DEF_DATA_W-1:PAGE_W] == '0));

    // R3
    window_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_win) |=> (addr != $past(addr)) || (rd_data == $past(wr_data)));

    // R5
    cal_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_cal) |=>
        byte_at(cal_vec, MASK_IDX_W'($past(addr) - CAL_LO)) == $past(wr_data));

    // R6
    pd_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_pd) |=>
        byte_at(pd_vec, MASK_IDX_W'($past(addr) - PD_LO)) == $past(wr_data));

    // R7
    vectors_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pd_vec) && $stable(cal_vec));

    // R8
    unused_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_unused |-> (rd_data == '0));

    // R9
    window_write_spares_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_win) |=> $stable(pd_vec) && $stable(cal_vec));

endmodule

bind chan_cfg_regfile chan_cfg_regfile_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .pd_vec (pd_vec),
    .cal_vec(cal_vec)
);

// File: tb/tb_chan_cfg_regfile.sv
`timescale 1ns/1ps
module tb_chan_cfg_regfile;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   addr = 8'd0;
    logic [7:0]   wr_data = 8'd0;
    logic [7:0]   rd_data;
    logic [127:0] pd_vec;
    logic [127:0] cal_vec;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    chan_cfg_regfile dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .pd_vec (pd_vec),
        .cal_vec(cal_vec)
    );

    // ---------------- reference model ----------------
    logic [1:0]   m_page;
    logic [7:0]   m_trim [4][128];
    logic [127:0] m_pd;
    logic [127:0] m_cal;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_page = 2'd0;
            m_pd   = '0;
            m_cal  = '0;
            for (int p = 0; p < 4; p++)
                for (int c = 0; c < 128; c++)
                    m_trim[p][c] = 8'h00;
        end else if (wr_en) begin
            int a;
            int sh;
            a = int'(addr);
            if (a >= 128) begin
                m_trim[m_page][7'(a - 128)] = wr_data;
            end else if (a == 0) begin
                m_page = wr_data[1:0];
            end else if (a >= 64 && a < 80) begin
                sh = (a - 64) * 8;
                m_cal = (m_cal & ~(128'hFF << sh)) | (128'(wr_data) << sh);
            end else if (a >= 80 && a < 96) begin
                sh = (a - 80) * 8;
                m_pd = (m_pd & ~(128'hFF << sh)) | (128'(wr_data) << sh);
            end
        end
    end

    function automatic logic [7:0] ref_rd(input int a);
        if (a >= 128) return m_trim[m_page][7'(a - 128)];
        if (a == 0) return {6'd0, m_page};
        if (a >= 64 && a < 80) return 8'(m_cal >> ((a - 64) * 8));
        if (a >= 80 && a < 96) return 8'(m_pd >> ((a - 80) * 8));
        return 8'h00;
    endfunction

    function automatic string tag_of(input int a);
        if (a >= 128) return "R3";
        if (a == 0) return "R2";
        if (a >= 64 && a < 80) return "R5";
        if (a >= 80 && a < 96) return "R6";
        return "R8";
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (addr %0d, t=%0t)", tag, act, exp, addr, $time);
        end
    endtask

    // Per-cycle comparison against the model, mid-cycle
    always @(negedge clk) begin
        if (started && !done) begin
            if (!rst_n) begin
                chk("R1", 128'(rd_data), 128'(ref_rd(int'(addr))));
                chk("R1", pd_vec, m_pd);
                chk("R1", cal_vec, m_cal);
            end else begin
                chk(tag_of(int'(addr)), 128'(rd_data), 128'(ref_rd(int'(addr))));
                chk("R6", pd_vec, m_pd);
                chk("R5", cal_vec, m_cal);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wr_data = d;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        wr_en = 1'b0; addr = a; wr_data = 8'h00;
        #1;
        chk(tag, 128'(rd_data), 128'(exp));
    endtask

    task automatic idle();
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [127:0] pd_snap;
        logic [127:0] cal_snap;
        @(posedge clk);
        started = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset contents
        rd_chk(8'd0,   8'h00, "R1");
        rd_chk(8'd64,  8'h00, "R1");
        rd_chk(8'd95,  8'h00, "R1");
        rd_chk(8'd128, 8'h00, "R1");
        rd_chk(8'd255, 8'h00, "R1");
        #1 chk("R1", pd_vec, '0);
        chk("R1", cal_vec, '0);

        // R2: page select in bits [1:0], upper bits dropped
        wr(8'd0, 8'hFF);
        rd_chk(8'd0, 8'h03, "R2");
        wr(8'd0, 8'hA4);
        rd_chk(8'd0, 8'h00, "R2");

        // R3/R4: fill each page with a distinct pattern on a few channels
        for (int p = 0; p < 4; p++) begin
            wr(8'd0, 8'(p));
            wr(8'd128, 8'(8'h10 * p + 1));
            wr(8'd191, 8'(8'h20 + p));
            wr(8'd255, 8'(8'hF0 | p));
            rd_chk(8'd255, 8'(8'hF0 | p), "R3");
        end
        for (int p = 3; p >= 0; p--) begin
            wr(8'd0, 8'(p));
            rd_chk(8'd128, 8'(8'h10 * p + 1), "R4");
            rd_chk(8'd191, 8'(8'h20 + p), "R4");
            rd_chk(8'd255, 8'(8'hF0 | p), "R4");
        end

        // R5/R6/R7: mask bytes, bit k of byte i -> channel 8i+k
        wr(8'd80, 8'h01);
        idle(); #1;
        chk("R7", pd_vec, 128'h1);
        wr(8'd95, 8'h80);
        idle(); #1;
        chk("R6", pd_vec, {1'b1, 126'd0, 1'b1});
        wr(8'd64, 8'hA5);
        wr(8'd79, 8'h3C);
        idle(); #1;
        chk("R5", cal_vec, {8'h3C, 112'd0, 8'hA5});
        rd_chk(8'd79, 8'h3C, "R5");
        rd_chk(8'd95, 8'h80, "R6");

        // R8: unused addresses ignore writes and read zero
        pd_snap = pd_vec; cal_snap = cal_vec;
        wr(8'd1, 8'hFF);
        wr(8'd63, 8'h77);
        wr(8'd96, 8'h55);
        wr(8'd127, 8'hAA);
        rd_chk(8'd1,   8'h00, "R8");
        rd_chk(8'd63,  8'h00, "R8");
        rd_chk(8'd96,  8'h00, "R8");
        rd_chk(8'd127, 8'h00, "R8");
        #1 chk("R8", pd_vec, pd_snap);
        chk("R8", cal_vec, cal_snap);
        rd_chk(8'd0, 8'h00, "R8");

        // R9: window writes leave masks and page alone
        wr(8'd0, 8'd2);
        pd_snap = pd_vec; cal_snap = cal_vec;
        for (int c = 0; c < 128; c += 9) wr(8'(128 + c), 8'(c ^ 8'h5A));
        idle(); #1;
        chk("R9", pd_vec, pd_snap);
        chk("R9", cal_vec, cal_snap);
        rd_chk(8'd0, 8'h02, "R9");
        rd_chk(8'd137, 8'(9 ^ 8'h5A), "R3");

        // Random traffic, compared each cycle by the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [7:0] a;
            r = int'($urandom_range(0, 9));
            case (r)
                0:       a = 8'd0;
                1, 2:    a = 8'(64 + $urandom_range(0, 31));
                3:       a = 8'($urandom_range(0, 127));
                default: a = 8'(128 + $urandom_range(0, 127));
            endcase
            @(posedge clk); #1;
            wr_en = ($urandom_range(0, 2) != 0);
            addr = a;
            wr_data = 8'($urandom);
        end
        idle();
        repeat (2) @(posedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule